// File: doc/BRIEF.md
# UART control-register access gate

This block is the host-facing control-register front end of a UART. It decodes byte writes and reads on a small address/data bus, and it holds the line control register. Writing one reserved "unlock" value to that register swaps most of the addresses over to a second register bank. That bank holds the enhanced-features register, two XON characters, two XOFF characters and the two divisor-latch bytes. The unlock write sets only the top bit of the line control register, so the data-format bits that the serial engines use are left unchanged.

The block also holds the FIFO control register and enforces the rule for when its depth-select bit may change. From that register, the enhanced-mode enable and the FIFO-select strap it derives the effective FIFO depth and whether the transmit trigger level is pinned to one. Every output comes straight from a register. A read returns its byte one clock after the read strobe. The functions behind the registers (baud generation, flow control, the FIFOs themselves) sit in other blocks that consume these outputs.

The line control register is at address 3 in both banks, so the host can always leave the second bank. In the normal bank, address 2 is the FIFO control register. Addresses 0, 1 and 4 to 7 are general byte registers, stored in a small RAM, for the other UART functions. In the second bank, the addresses map as follows:
- 0: divisor low
- 1: divisor high
- 2: enhanced features
- 4: XON1
- 5: XON2
- 6: XOFF1
- 7: XOFF2

Top module: `uart_regbank_gate`

## Requirements
- R1: While the second bank is selected, writes to addresses 0, 1, 2, 4, 5, 6 and 7 update, in that order, divisor low, divisor high, enhanced features, XON1, XON2, XOFF1 and XOFF2. These writes leave the FIFO control register and the general registers unchanged.
- R2: A write of 0xBF to address 3 sets bit 7 of the line control register and keeps bits 6:0 unchanged. It also selects the second bank (`alt_bank_o`=1) from the next cycle.
- R3: A write of any other value to address 3 stores the whole byte in the line control register and deselects the second bank.
- R4: While the normal bank is selected, a write to address 2 goes to the FIFO control register and a write to addresses 0, 1, 4 to 7 goes to the general register at that address. The second-bank registers are unchanged.
- R5: When enhanced mode is off (enhanced-features bit 4 = 0), the strap `fifo_sel_i` is low and line-control bit 7 is 0, a FIFO control write keeps FIFO-control bit 5 at its old value. It stores the other seven bits. In every other case all eight bits are stored.
- R6: When enhanced mode is off, FIFO-control bit 5 selects the depth: 0 gives 16 bytes and 1 gives 128 bytes (`fifo_large_o` is 1 for 128 bytes). The depth outputs follow the register state one cycle later.
- R7: When enhanced mode is on, FIFO-control bit 0 selects the depth in place of bit 5: 0 gives 16 bytes and 1 gives 128 bytes. This also takes one cycle.
- R8: When enhanced mode is off, `tx_trig_one_o` is 1 one cycle later, and FIFO-control bit 4 has no effect on the trigger or depth outputs. When enhanced mode is on, `tx_trig_one_o` is 0.
- R9: A read returns its byte on `rdata_o` one cycle after `rd_i`, and holds it until the next read. The byte comes from the bank selected at the time of the read, and it is the value from before any write in the same cycle. Address 3 always reads the line control register.
- R10: After a synchronous reset the following hold:
  - the line control, FIFO control, enhanced-features, divisor and character registers are 0;
  - the normal bank is selected;
  - the depth is 16 with `fifo_large_o`=0;
  - `tx_trig_one_o`=1 and `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_sel_i | input | 1 | FIFO-select strap; high releases the depth-bit lock |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid one cycle after the strobe |
| lcr_o | output | 8 | Line control register; bits 6:0 are the data format |
| alt_bank_o | output | 1 | Second register bank selected |
| fcr_o | output | 8 | FIFO control register |
| efr_o | output | 8 | Enhanced-features register; bit 4 enables enhanced mode |
| dll_o | output | 8 | Divisor latch low byte |
| dlm_o | output | 8 | Divisor latch high byte |
| xon1_o | output | 8 | First XON character |
| xon2_o | output | 8 | Second XON character |
| xoff1_o | output | 8 | First XOFF character |
| xoff2_o | output | 8 | Second XOFF character |
| fifo_depth_o | output | 8 | Effective FIFO depth in bytes |
| fifo_large_o | output | 1 | 128-byte depth selected |
| tx_trig_one_o | output | 1 | Transmit trigger level is 1 |

## Verification
The assertions check the following on every cycle:
- the line-control effect of unlock and ordinary writes;
- the bit-5 lock whenever its three conditions meet;
- that each bank's writes leave the other bank's registers stable;
- the one-cycle depth and trigger derivation in both modes;
- the reset values.

Only the bench's scenarios can show that the general registers in RAM survive a visit to the second bank. The same holds for the read-before-write order of a read and a write in one cycle, and for the strap releasing the lock. They also show that the data format holds through the full enter-and-leave sequence, because these need reads at chosen points compared against a reference model.

// File: rtl/uart_gate_pkg.sv
package uart_gate_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DLL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DLM  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_LCR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CHR0 = 3'd4;

  localparam int unsigned N_CHR       = 4;
  localparam int unsigned N_REGS      = 1 << ADDR_W;
  localparam int unsigned BIT_ENH     = 4;
  localparam int unsigned BIT_DEPTH   = 5;
  localparam int unsigned BIT_FIFO_EN = 0;
  localparam int unsigned BIT_GATE    = 7;

  typedef struct packed {
    logic             lcr;
    logic             fcr;
    logic             nrm;
    logic             efr;
    logic             dll;
    logic             dlm;
    logic [N_CHR-1:0] chr;
  } wr_dec_t;

endpackage

// File: rtl/uart_gate_decode.sv
module uart_gate_decode
  import uart_gate_pkg::*;
(
  input  logic              alt_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_dec_t           dec_o
);

  logic is_lcr;
  logic is_chr;
  logic [ADDR_W-1:0] chr_idx;

  assign is_lcr  = (addr_i == A_LCR);
  assign is_chr  = (addr_i >= A_CHR0);
  assign chr_idx = addr_i - A_CHR0;

  always_comb begin
    dec_o     = '0;
    dec_o.lcr = wr_i && is_lcr;
    if (wr_i && !is_lcr) begin
      if (alt_i) begin
        dec_o.dll = (addr_i == A_DLL);
        dec_o.dlm = (addr_i == A_DLM);
        dec_o.efr = (addr_i == A_CTRL);
        for (int i = 0; i < N_CHR; i++) begin
          dec_o.chr[i] = is_chr && (chr_idx == ADDR_W'(i));
        end
      end else begin
        dec_o.fcr = (addr_i == A_CTRL);
        dec_o.nrm = (addr_i != A_CTRL);
      end
    end
  end

endmodule

// File: rtl/uart_gate_lcr.sv
module uart_gate_lcr #(
  parameter int unsigned          DATA_W = 8,
  parameter logic [DATA_W-1:0]    MAGIC  = 8'hBF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] lcr_o,
  output logic              alt_o
);

  localparam int unsigned TOP = DATA_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_o <= '0;
      alt_o <= 1'b0;
    end else if (we_i) begin
      if (wdata_i == MAGIC) begin
        lcr_o[TOP] <= 1'b1;
        alt_o      <= 1'b1;
      end else begin
        lcr_o <= wdata_i;
        alt_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_gate_ext.sv
module uart_gate_ext
  import uart_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_dec_t           dec_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] efr_o,
  output logic [DATA_W-1:0] dll_o,
  output logic [DATA_W-1:0] dlm_o,
  output logic [DATA_W-1:0] chr_o [N_CHR]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      efr_o <= '0;
      dll_o <= '0;
      dlm_o <= '0;
    end else begin
      if (dec_i.efr) efr_o <= wdata_i;
      if (dec_i.dll) dll_o <= wdata_i;
      if (dec_i.dlm) dlm_o <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_CHR; g++) begin : g_chr
    always_ff @(posedge clk) begin
      if (rst) begin
        chr_o[g] <= '0;
      end else if (dec_i.chr[g]) begin
        chr_o[g] <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/uart_gate_fifo.sv
module uart_gate_fifo
  import uart_gate_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DEPTH_SMALL = 16,
  parameter int unsigned DEPTH_LARGE = 128,
  parameter int unsigned DEPTH_W     = $clog2(DEPTH_LARGE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               enh_i,
  input  logic               gate_i,
  input  logic               strap_i,
  output logic [DATA_W-1:0]  fcr_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               large_o,
  output logic               trig_one_o
);

  logic              locked;
  logic [DATA_W-1:0] fcr_next;
  logic              large_next;

  assign locked = !enh_i && !strap_i && !gate_i;

  always_comb begin
    fcr_next = wdata_i;
    if (locked) fcr_next[BIT_DEPTH] = fcr_o[BIT_DEPTH];
  end

  assign large_next = enh_i ? fcr_o[BIT_FIFO_EN] : fcr_o[BIT_DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      fcr_o      <= '0;
      depth_o    <= DEPTH_W'(DEPTH_SMALL);
      large_o    <= 1'b0;
      trig_one_o <= 1'b1;
    end else begin
      if (we_i) fcr_o <= fcr_next;
      large_o    <= large_next;
      depth_o    <= large_next ? DEPTH_W'(DEPTH_LARGE) : DEPTH_W'(DEPTH_SMALL);
      trig_one_o <= !enh_i;
    end
  end

endmodule

// File: rtl/uart_regbank_gate.sv
module uart_regbank_gate
  import uart_gate_pkg::*;
#(
  parameter int unsigned       DATA_W      = 8,
  parameter logic [DATA_W-1:0] MAGIC       = 8'hBF,
  parameter int unsigned       DEPTH_SMALL = 16,
  parameter int unsigned       DEPTH_LARGE = 128,
  parameter int unsigned       DEPTH_W     = $clog2(DEPTH_LARGE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_sel_i,
  input  logic [2:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_i,
  input  logic               rd_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [DATA_W-1:0]  lcr_o,
  output logic               alt_bank_o,
  output logic [DATA_W-1:0]  fcr_o,
  output logic [DATA_W-1:0]  efr_o,
  output logic [DATA_W-1:0]  dll_o,
  output logic [DATA_W-1:0]  dlm_o,
  output logic [DATA_W-1:0]  xon1_o,
  output logic [DATA_W-1:0]  xon2_o,
  output logic [DATA_W-1:0]  xoff1_o,
  output logic [DATA_W-1:0]  xoff2_o,
  output logic [DEPTH_W-1:0] fifo_depth_o,
  output logic               fifo_large_o,
  output logic               tx_trig_one_o
);

  wr_dec_t           dec;
  logic [DATA_W-1:0] chr [N_CHR];
  logic [DATA_W-1:0] mem [N_REGS];
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] val_d;
  logic [DATA_W-1:0] val_q;
  logic              src_mem_d;
  logic              src_mem_q;

  uart_gate_decode u_dec (
    .alt_i  (alt_bank_o),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  uart_gate_lcr #(.DATA_W(DATA_W), .MAGIC(MAGIC)) u_lcr (
    .clk     (clk),
    .rst     (rst),
    .we_i    (dec.lcr),
    .wdata_i (wdata_i),
    .lcr_o   (lcr_o),
    .alt_o   (alt_bank_o)
  );

  uart_gate_ext #(.DATA_W(DATA_W)) u_ext (
    .clk     (clk),
    .rst     (rst),
    .dec_i   (dec),
    .wdata_i (wdata_i),
    .efr_o   (efr_o),
    .dll_o   (dll_o),
    .dlm_o   (dlm_o),
    .chr_o   (chr)
  );

  assign xon1_o  = chr[0];
  assign xon2_o  = chr[1];
  assign xoff1_o = chr[2];
  assign xoff2_o = chr[3];

  uart_gate_fifo #(
    .DATA_W      (DATA_W),
    .DEPTH_SMALL (DEPTH_SMALL),
    .DEPTH_LARGE (DEPTH_LARGE),
    .DEPTH_W     (DEPTH_W)
  ) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .we_i       (dec.fcr),
    .wdata_i    (wdata_i),
    .enh_i      (efr_o[BIT_ENH]),
    .gate_i     (lcr_o[BIT_GATE]),
    .strap_i    (fifo_sel_i),
    .fcr_o      (fcr_o),
    .depth_o    (fifo_depth_o),
    .large_o    (fifo_large_o),
    .trig_one_o (tx_trig_one_o)
  );

  // General registers: read-first RAM with a synchronous read port
  always_ff @(posedge clk) begin
    if (dec.nrm) mem[addr_i] <= wdata_i;
    if (rd_i) mem_q <= mem[addr_i];
  end

  always_comb begin
    val_d     = '0;
    src_mem_d = 1'b0;
    if (addr_i == A_LCR) begin
      val_d = lcr_o;
    end else if (alt_bank_o) begin
      if (addr_i == A_DLL)       val_d = dll_o;
      else if (addr_i == A_DLM)  val_d = dlm_o;
      else if (addr_i == A_CTRL) val_d = efr_o;
      else                       val_d = chr[addr_i - A_CHR0];
    end else if (addr_i == A_CTRL) begin
      val_d = fcr_o;
    end else begin
      src_mem_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q     <= '0;
      src_mem_q <= 1'b0;
    end else if (rd_i) begin
      val_q     <= val_d;
      src_mem_q <= src_mem_d;
    end
  end

  assign rdata_o = src_mem_q ? mem_q : val_q;

endmodule

// File: rtl/uart_gate_chk.sv
module uart_gate_chk #(
  parameter int unsigned       DATA_W  = 8,
  parameter logic [DATA_W-1:0] MAGIC   = 8'hBF,
  parameter int unsigned       DEPTH_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               fifo_sel_i,
  input logic [2:0]         addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               wr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [DATA_W-1:0]  lcr_o,
  input logic               alt_bank_o,
  input logic [DATA_W-1:0]  fcr_o,
  input logic [DATA_W-1:0]  efr_o,
  input logic [DATA_W-1:0]  dll_o,
  input logic [DATA_W-1:0]  dlm_o,
  input logic               fifo_large_o,
  input logic               tx_trig_one_o
);

  logic lcr_wr;
  logic ctl_wr;
  assign lcr_wr = wr_i && (addr_i == 3'd3);
  assign ctl_wr = wr_i && (addr_i != 3'd3);

  p_magic_keeps_format_r2: assert property (@(posedge clk) disable iff (rst)
    (lcr_wr && wdata_i == MAGIC) |=>
      (lcr_o[DATA_W-2:0] == $past(lcr_o[DATA_W-2:0])) && lcr_o[DATA_W-1] && alt_bank_o);

  p_plain_lcr_store_r3: assert property (@(posedge clk) disable iff (rst)
    (lcr_wr && wdata_i != MAGIC) |=> (lcr_o == $past(wdata_i)) && !alt_bank_o);

  p_alt_spares_fcr_r1: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && alt_bank_o) |=> $stable(fcr_o));

  p_normal_spares_alt_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !alt_bank_o) |=> $stable(efr_o) && $stable(dll_o) && $stable(dlm_o));

  p_depth_bit_locked_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !alt_bank_o && addr_i == 3'd2 && !efr_o[4] && !fifo_sel_i && !lcr_o[DATA_W-1])
      |=> (fcr_o[5] == $past(fcr_o[5])));

  p_depth_plain_r6: assert property (@(posedge clk) disable iff (rst)
    (!efr_o[4]) |=> (fifo_large_o == $past(fcr_o[5])));

  p_depth_enh_r7: assert property (@(posedge clk) disable iff (rst)
    (efr_o[4]) |=> (fifo_large_o == $past(fcr_o[0])));

  p_trig_one_r8: assert property (@(posedge clk) disable iff (rst)
    (!efr_o[4]) |=> tx_trig_one_o);

  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (lcr_o == '0) && !alt_bank_o && (fcr_o == '0) && (efr_o == '0)
            && !fifo_large_o && tx_trig_one_o && (rdata_o == '0));

endmodule

bind uart_regbank_gate uart_gate_chk #(
  .DATA_W  (DATA_W),
  .MAGIC   (MAGIC),
  .DEPTH_W (DEPTH_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fifo_sel_i    (fifo_sel_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .wr_i          (wr_i),
  .rdata_o       (rdata_o),
  .lcr_o         (lcr_o),
  .alt_bank_o    (alt_bank_o),
  .fcr_o         (fcr_o),
  .efr_o         (efr_o),
  .dll_o         (dll_o),
  .dlm_o         (dlm_o),
  .fifo_large_o  (fifo_large_o),
  .tx_trig_one_o (tx_trig_one_o)
);

// File: tb/uart_regbank_gate_bench.sv
`timescale 1ns/1ps
module uart_regbank_gate_bench;

  localparam real CYC = 5.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_sel_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o, lcr_o, fcr_o, efr_o, dll_o, dlm_o;
  logic [7:0] xon1_o, xon2_o, xoff1_o, xoff2_o, fifo_depth_o;
  logic       alt_bank_o, fifo_large_o, tx_trig_one_o;

  always #(CYC/2) clk = ~clk;

  uart_regbank_gate u_uart_regbank_gate (
    .clk(clk), .rst(rst), .fifo_sel_i(fifo_sel_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .lcr_o(lcr_o), .alt_bank_o(alt_bank_o), .fcr_o(fcr_o), .efr_o(efr_o),
    .dll_o(dll_o), .dlm_o(dlm_o), .xon1_o(xon1_o), .xon2_o(xon2_o),
    .xoff1_o(xoff1_o), .xoff2_o(xoff2_o), .fifo_depth_o(fifo_depth_o),
    .fifo_large_o(fifo_large_o), .tx_trig_one_o(tx_trig_one_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_lcr, m_fcr, m_efr, m_dll, m_dlm, m_rdata, m_large, m_trig;
  int m_chr [4];
  int m_mem [8];
  bit m_alt;

  always @(posedge clk) begin
    if (rst) begin
      m_lcr = 0; m_fcr = 0; m_efr = 0; m_dll = 0; m_dlm = 0; m_alt = 0;
      m_rdata = 0; m_large = 0; m_trig = 1;
      foreach (m_chr[i]) m_chr[i] = 0;
    end else begin
      bit enh;
      enh = m_efr[4];
      m_large = enh ? m_fcr[0] : m_fcr[5];
      m_trig = enh ? 0 : 1;
      if (rd_i) begin
        int a;
        a = addr_i;
        if (a == 3) m_rdata = m_lcr;
        else if (m_alt) begin
          if (a == 0) m_rdata = m_dll;
          else if (a == 1) m_rdata = m_dlm;
          else if (a == 2) m_rdata = m_efr;
          else m_rdata = m_chr[a-4];
        end else if (a == 2) m_rdata = m_fcr;
        else m_rdata = m_mem[a];
      end
      if (wr_i) begin
        int a, d;
        a = addr_i; d = wdata_i;
        if (a == 3) begin
          if (d == 'hBF) begin m_lcr = m_lcr | 'h80; m_alt = 1; end
          else begin m_lcr = d; m_alt = 0; end
        end else if (m_alt) begin
          if (a == 0) m_dll = d;
          else if (a == 1) m_dlm = d;
          else if (a == 2) m_efr = d;
          else m_chr[a-4] = d;
        end else if (a == 2) begin
          if (!enh && !fifo_sel_i && !m_lcr[7]) m_fcr = (d & 'hDF) | (m_fcr & 'h20);
          else m_fcr = d;
        end else m_mem[a] = d;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 lcr", lcr_o, m_lcr);
      chk("R3 bank", alt_bank_o, m_alt);
      chk("R5 fcr", fcr_o, m_fcr);
      chk("R1 efr", efr_o, m_efr);
      chk("R1 dll", dll_o, m_dll);
      chk("R1 dlm", dlm_o, m_dlm);
      chk("R1 xon1", xon1_o, m_chr[0]);
      chk("R1 xon2", xon2_o, m_chr[1]);
      chk("R1 xoff1", xoff1_o, m_chr[2]);
      chk("R1 xoff2", xoff2_o, m_chr[3]);
      chk("R6 large", fifo_large_o, m_large);
      chk("R7 depth", fifo_depth_o, m_large ? 128 : 16);
      chk("R8 trig", tx_trig_one_o, m_trig);
      chk("R9 rdata", rdata_o, m_rdata);
    end
  end

  task automatic wr(input int a, input int d);
    addr_i = 3'(a); wdata_i = 8'(d); wr_i = 1;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic rd(input int a, output int v);
    addr_i = 3'(a); rd_i = 1;
    @(negedge clk); rd_i = 0; v = rdata_o;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk("R10 lcr", lcr_o, 0);
    chk("R10 depth", fifo_depth_o, 16);
    chk("R10 trig", tx_trig_one_o, 1);
    chk("R10 bank", alt_bank_o, 0);
    rst = 0;
    idle();
    // R4 general registers and normal-bank FCR
    wr(3, 'h03);
    for (int a = 0; a < 8; a++) if (a != 2 && a != 3) wr(a, 'h50 + a);
    rd(5, v); chk("R4 gen reg5", v, 'h55);
    rd(3, v); chk("R9 lcr read", v, 'h03);
    // R5 locked depth bit
    wr(2, 'h21); idle();
    chk("R5 locked", fcr_o, 'h01);
    chk("R6 small", fifo_depth_o, 16);
    // gate open via LCR bit 7 without unlock value
    wr(3, 'h83); wr(2, 'h21); idle(); idle();
    chk("R6 large", fifo_depth_o, 128);
    // R8 bit 4 no effect in plain mode
    wr(2, 'h31); idle(); idle();
    chk("R8 trig plain", tx_trig_one_o, 1);
    chk("R8 depth kept", fifo_depth_o, 128);
    // R2 unlock keeps format
    wr(3, 'h03); wr(3, 'hBF);
    chk("R2 format", lcr_o, 'h83);
    chk("R2 bank", alt_bank_o, 1);
    wr(0, 'h12); wr(1, 'h34); wr(4, 'h11); wr(5, 'h13); wr(6, 'h91); wr(7, 'h93);
    wr(2, 'h10);
    rd(6, v); chk("R1 xoff1 read", v, 'h91);
    rd(2, v); chk("R1 efr read", v, 'h10);
    chk("R1 fcr untouched", fcr_o, 'h31);
    // R3 leave bank
    wr(3, 'h1B);
    chk("R3 stored", lcr_o, 'h1B);
    rd(4, v); chk("R4 gen survives", v, 'h54);
    idle(); idle();
    // R7 enhanced: bit 0 selects depth
    chk("R8 trig enh", tx_trig_one_o, 0);
    wr(2, 'h20); idle(); idle();
    chk("R7 enh small", fifo_depth_o, 16);
    chk("R5 enh writable", fcr_o, 'h20);
    wr(2, 'h01); idle(); idle();
    chk("R7 enh large", fifo_depth_o, 128);
    // back to plain, strap releases lock
    wr(3, 'hBF); wr(2, 'h00); wr(3, 'h03); idle();
    fifo_sel_i = 1; wr(2, 'h20); idle(); idle();
    chk("R5 strap", fcr_o, 'h20);
    fifo_sel_i = 0;
    // R9 read and write same cycle returns old
    addr_i = 3'd7; wdata_i = 8'hEE; wr_i = 1; rd_i = 1;
    @(negedge clk); wr_i = 0; rd_i = 0;
    chk("R9 read first", rdata_o, 'h57);
    rd(7, v); chk("R9 new value", v, 'hEE);
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule